// File: doc/BRIEF.md
# Reset Stretcher With Stability Flag

This block sits between the external reset pin and the rest of a chip. It holds the internal reset low after the external reset has gone high, for a fixed number of reference clock cycles. During that time a crystal or an on-chip oscillator can settle. The length of the hold depends on a clock-source strap. When the strap selects an external clock source, the hold is short. When it selects the on-chip oscillator, the hold is long.

When the external reset goes low, the internal reset and every status output clear at once, without waiting for a clock edge. When the external reset goes high again, that release passes through a synchronizer. After the synchronizer, the block emits a one-cycle capture strobe, and configuration logic uses it to latch its straps. The block latches its own clock-source strap at the same edge. It then counts reference cycles.

While the count runs, the block tells the clock tree to bypass its dividers and drive reference/8 on every output. When the count completes, the internal reset is released and the forced divide is dropped. At the same time a stable flag rises, and it stays high until the next external reset.

Top module: `rst_stretch_ctrl`

## Requirements
- R1: While `ext_rst_n` is 0, `int_rst_n` is 0, `osc_stable` is 0, `div8_force` is 1, `cfg_capture` is 0 and `src_sel_q` is 0. These values appear as soon as `ext_rst_n` falls, with no clock edge needed.
- R2: A rising `ext_rst_n` passes through SYNC_STAGES flops. `cfg_capture` is 1 for exactly one cycle, starting after clock edge SYNC_STAGES+1 counted from the release.
- R3: `src_sel` is sampled at the edge that raises `cfg_capture` and appears on `src_sel_q`. Changes to `src_sel` after that edge affect neither `src_sel_q` nor the hold length until the next external reset.
- R4: With `src_sel` = 1 (external clock source), `int_rst_n` rises after edge SYNC_STAGES+1+SHORT_CYCLES, where SHORT_CYCLES is 512 by default. Before that edge it is 0.
- R5: With `src_sel` = 0 (on-chip oscillator), `int_rst_n` rises after edge SYNC_STAGES+1+LONG_CYCLES, where LONG_CYCLES is 4096 by default. Before that edge it is 0.
- R6: `osc_stable` is 0 while the count is in progress. It becomes 1 in the same cycle that `int_rst_n` becomes 1. It then stays 1 because the counter saturates.
- R7: `div8_force` is 1 exactly while `int_rst_n` is 0.
- R8: If `ext_rst_n` falls during the count, the outputs clear as in R1. The next release restarts the synchronizer and the full count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected input reference clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assertion |
| src_sel | input | 1 | Clock-source strap: 1 selects the external clock, 0 selects the on-chip oscillator |
| int_rst_n | output | 1 | Stretched internal reset, active low |
| osc_stable | output | 1 | Sticky flag: the reference clock has been counted as stable |
| div8_force | output | 1 | Tells the clock tree to bypass its dividers and drive reference/8 |
| cfg_capture | output | 1 | One-cycle strobe telling configuration logic to latch its straps |
| src_sel_q | output | 1 | Clock-source strap as latched at the capture strobe |

## Verification
The hardest situation to reach is an external reset that arrives partway through the count, followed by a release whose count must start again from zero rather than carry on. The bench builds the block with short hold lengths. It aborts the count at every offset from the first synchronizer edge through the last counting cycle, and each abort is followed by a complete tracked release. It also flips the strap right after the capture strobe and checks that the hold length still follows the strap as latched.

// File: rtl/rstx_pkg.sv
package rstx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_DONE  = 2'd2
  } rstx_phase_e;

  function automatic int unsigned rstx_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstx_sync.sv
module rstx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rel_sync = chain_q[STAGES-1];

  // R2: once released, the synchronized release stays high until reset
  assert_sync_holds_R2: assert property (@(posedge clk) disable iff (!arst_n)
    rel_sync |=> rel_sync);

endmodule

// File: rtl/rstx_counter.sv
module rstx_counter #(
  parameter int unsigned CW = 13
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  input  logic [CW-1:0] target,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == target);
  assign last   = en && !at_end && (cnt_q == target - CW'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             cnt_q <= '0;
    else if (en && !at_end)  cnt_q <= cnt_q + CW'(1);
  end

  // R6: saturating counter never passes its terminal value
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= target);

endmodule

// File: rtl/rst_stretch_ctrl.sv
module rst_stretch_ctrl
  import rstx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SHORT_CYCLES = 512,
  parameter int unsigned LONG_CYCLES  = 4096
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic src_sel,
  output logic int_rst_n,
  output logic osc_stable,
  output logic div8_force,
  output logic cfg_capture,
  output logic src_sel_q
);

  localparam int unsigned MAXC = rstx_max(SHORT_CYCLES, LONG_CYCLES);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  rstx_phase_e   phase_q;
  logic          rel_sync;
  logic          cnt_last;
  logic [CW-1:0] target;
  logic          counting;

  rstx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arst_n   (ext_rst_n),
    .rel_sync (rel_sync)
  );

  assign target   = src_sel_q ? CW'(SHORT_CYCLES) : CW'(LONG_CYCLES);
  assign counting = (phase_q == PH_COUNT);

  rstx_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .en     (counting),
    .target (target),
    .last   (cnt_last)
  );

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      phase_q     <= PH_IDLE;
      cfg_capture <= 1'b0;
      src_sel_q   <= 1'b0;
    end else begin
      cfg_capture <= 1'b0;
      case (phase_q)
        PH_IDLE: if (rel_sync) begin
          phase_q     <= PH_COUNT;
          cfg_capture <= 1'b1;
          src_sel_q   <= src_sel;
        end
        PH_COUNT: if (cnt_last) phase_q <= PH_DONE;
        default:  phase_q <= PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      int_rst_n  <= 1'b0;
      osc_stable <= 1'b0;
      div8_force <= 1'b1;
    end else if (cnt_last) begin
      int_rst_n  <= 1'b1;
      osc_stable <= 1'b1;
      div8_force <= 1'b0;
    end
  end

  // R6: stable flag is sticky until the next external reset
  assert_stable_sticky_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    osc_stable |=> osc_stable);

  // R2: capture strobe lasts a single cycle
  assert_capture_single_R2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    cfg_capture |=> !cfg_capture);

  // R3: latched strap holds once the count has started
  assert_strap_frozen_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (phase_q != PH_IDLE) |=> $stable(src_sel_q));

  // R7: forced divide and internal reset stay complementary
  assert_force_matches_R7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    div8_force == !int_rst_n);

  // R4: internal reset only releases after the capture strobe has passed
  assert_release_after_capture_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(int_rst_n) |-> !cfg_capture);

endmodule

// File: tb/test_rst_stretch_ctrl.sv
module test_rst_stretch_ctrl;

  localparam int SYNC  = 2;
  localparam int SHORT = 5;
  localparam int LONG  = 11;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic src_sel = 1'b0;
  logic int_rst_n, osc_stable, div8_force, cfg_capture, src_sel_q;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_stretch_ctrl #(
    .SYNC_STAGES(SYNC), .SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)
  ) i_rst_stretch_ctrl (
    .clk(clk), .ext_rst_n(ext_rst_n), .src_sel(src_sel),
    .int_rst_n(int_rst_n), .osc_stable(osc_stable), .div8_force(div8_force),
    .cfg_capture(cfg_capture), .src_sel_q(src_sel_q)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_cleared(input string req);
    chk(req, "int_rst_n", int_rst_n, 1'b0);
    chk(req, "osc_stable", osc_stable, 1'b0);
    chk(req, "div8_force", div8_force, 1'b1);
    chk(req, "cfg_capture", cfg_capture, 1'b0);
    chk(req, "src_sel_q", src_sel_q, 1'b0);
  endtask

  // Release at a negedge and follow every cycle of the stretch.
  task automatic run_release(input logic strap, input bit flip_after);
    int hold;
    int lat;
    hold = strap ? SHORT : LONG;
    lat  = SYNC + 1 + hold;
    @(negedge clk);
    src_sel   = strap;
    ext_rst_n = 1'b1;
    for (int e = 1; e <= lat + 3; e++) begin
      bit rel;
      @(posedge clk);
      @(negedge clk);
      rel = (e >= lat);
      chk(strap ? "R4" : "R5", "int_rst_n", int_rst_n, rel);
      chk("R6", "osc_stable", osc_stable, rel);
      chk("R7", "div8_force", div8_force, !rel);
      chk("R2", "cfg_capture", cfg_capture, (e == SYNC + 1));
      if (e >= SYNC + 1) chk("R3", "src_sel_q", src_sel_q, strap);
      if (flip_after && e == SYNC + 1) src_sel = ~strap;
    end
  endtask

  task automatic assert_reset_mid;
    #2;
    ext_rst_n = 1'b0;
    #1;
    chk_cleared("R1");
    @(negedge clk);
    chk_cleared("R8");
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_cleared("R1");

    run_release(1'b1, 1'b0);
    assert_reset_mid();
    run_release(1'b0, 1'b0);
    assert_reset_mid();
    // R3: strap flipped after capture must not change the hold
    run_release(1'b1, 1'b1);
    assert_reset_mid();
    run_release(1'b0, 1'b1);

    // R8: abort at every offset, then a full tracked release
    for (int s = 0; s < 2; s++) begin
      for (int k = 1; k <= SYNC + 1 + (s ? SHORT : LONG) - 1; k++) begin
        assert_reset_mid();
        @(negedge clk);
        src_sel   = logic'(s);
        ext_rst_n = 1'b1;
        repeat (k) @(negedge clk);
        assert_reset_mid();
        run_release(logic'(s), 1'b0);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule